// File: doc/BRIEF.md
# Interrupt Synchronizer and Combiner

This block collects the asynchronous interrupt sources of a processor core and turns them into the pending-interrupt field of a cause-style status word, plus a non-maskable request. There are six active-low interrupt pins, an active-low non-maskable pin, a timer request that comes from inside the core, and a strap that decides who owns the top interrupt line. Each pin passes through a chain of synchronizing flops on the system clock before it is used.

Software owns a seven-bit interrupt register through a small write/read port. Its low six bits are ORed into the six pending lines, so software can raise any line. Its top bit is a second source for the non-maskable request. The non-maskable request is a single-cycle pulse: it fires on a falling edge of the synchronized pin, or on a write that changes the top register bit from 0 to 1. Masking, priority and vectoring are left to the core that reads the outputs.

Top module: `irq_combiner`

## Requirements
- R1: While reset is low at a clock edge, the interrupt register clears to 0 and the non-maskable pulse is 0; with all pins inactive (high) and the strap high, the pending field reads 0 after reset.
- R2: A pin of the six interrupt pins held low sets the pending bit of the same index (bit k for pin k); a high pin contributes nothing.
- R3: Register bits 5:0 are ORed bit by bit into the pending field, independently of the pin levels; register bit k set means pending bit k is set from the cycle after the write.
- R4: The status word output carries the pending field in bits 15:10 (pending bit k at word bit 10+k); its bits 9:0 are always 0.
- R5: With the strap at 0, pending bit 5 follows the timer request in the same cycle (ORed with register bit 5), and interrupt pin 5 has no effect.
- R6: With the strap at 1, the timer request has no effect and pending bit 5 follows pin 5.
- R7: A falling edge of the non-maskable pin gives exactly one cycle of the non-maskable pulse, three clock edges after the pin falls; holding the pin low or releasing it gives no further pulse.
- R8: A register write that changes bit 6 from 0 to 1 gives a one-cycle non-maskable pulse in the cycle after the write; writing 1 to bit 6 when it is already 1 gives no pulse.
- R9: The register read port returns the last written value in the cycle after the write.
- R10: Every pin and the strap pass through two synchronizing flops: a pin change made after one clock edge is not visible after the next edge and is visible after the one following.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System interface clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_pin_n | input | 6 | External interrupt pins, active low |
| nmi_pin_n | input | 1 | Non-maskable interrupt pin, active low |
| timer_req | input | 1 | Internal timer interrupt request, active high, core clock domain |
| timer_off | input | 1 | Strap: 0 gives line 5 to the timer, 1 gives it to pin 5 |
| sw_wr | input | 1 | Write strobe for the interrupt register |
| sw_wdata | input | 7 | Write data for the interrupt register |
| sw_rdata | output | 7 | Current interrupt register value |
| pend_field | output | 6 | Combined pending interrupt lines |
| cause_word | output | 16 | Status word with the pending field in bits 15:10 |
| nmi_req | output | 1 | Non-maskable request pulse, one cycle |

## Verification
The bench builds the block with its default parameters: six lines, a two-flop synchronizer and the field placed at bit 10 of a sixteen-bit word. With that depth, the pin latency of two edges and the non-maskable pulse at the third edge are exact cycle counts the scoreboard can predict, so the one-cycle-early and one-cycle-late cases are both observable. The strap is toggled during the run, which brings both owners of the top line, the timer and pin 5, within reach of a single test, together with register writes that overlap active pins.

// File: rtl/irq_combiner_pkg.sv
// Package: shared constants and helpers for the interrupt combiner.
// Assumes: a single clock domain for everything downstream of the synchronizers.
package irq_combiner_pkg;

    // Default geometry of the pending field.
    localparam int DEF_NUM_IRQ     = 6;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_FIELD_LSB   = 10;
    localparam int DEF_WORD_W      = 16;

    // Place a pending field into a status word of the given width (all other bits zero).
    function automatic logic [63:0] place_field(input logic [63:0] field, input int lsb);
        return field << lsb;
    endfunction

endpackage

// File: rtl/irq_sync_chain.sv
// Module: multi-bit synchronizer chain.
// What it does: passes each bit through STAGES flops clocked by clk.
// Assumes: bits are independent levels; no bus coherency is needed across bits.
module irq_sync_chain #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop of the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_next
                // Later flops settle any metastable first-stage value.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/irq_soft_reg.sv
// Module: software interrupt register.
// What it does: holds the (NUM_IRQ+1)-bit register, reports a 0-to-1 write of the
// top bit as a one-cycle strobe (combinational, same cycle as the write strobe).
// Assumes: one write port; the read value is the register itself.
module irq_soft_reg #(
    parameter int NUM_IRQ = 6,
    localparam int REG_W  = NUM_IRQ + 1,
    localparam int TOP    = NUM_IRQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] value,
    output logic             top_rise
);

    logic [REG_W-1:0] reg_q;

    // Register update on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  reg_q <= '0;
        else if (wr) reg_q <= wdata;
    end

    // Detect a write that sets the top bit from 0.
    always_comb begin
        top_rise = wr && wdata[TOP] && !reg_q[TOP];
    end

    assign value = reg_q;

endmodule

// File: rtl/irq_nmi_pulse.sv
// Module: non-maskable request pulse former.
// What it does: emits one registered cycle of nmi_req on a falling edge of the
// synchronized active-low pin or on a software rise strobe.
// Assumes: pin_sync is already synchronized; its reset level is high (inactive).
module irq_nmi_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync_n,
    input  logic sw_rise,
    output logic nmi_req
);

    logic prev_n;
    logic fall_now;

    // Remember the last synchronized pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= 1'b1;
        else        prev_n <= pin_sync_n;
    end

    // Falling edge of the active-low pin.
    always_comb begin
        fall_now = prev_n && !pin_sync_n;
    end

    // Register the pulse so it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_req <= 1'b0;
        else        nmi_req <= fall_now || sw_rise;
    end

endmodule

// File: rtl/irq_merge.sv
// Module: pending-field merge.
// What it does: ORs each synchronized pin (active low) with its register bit; on
// the top line the strap chooses the pin or the internal timer request.
// Assumes: inputs are all in the clk domain; purely combinational.
module irq_merge #(
    parameter int NUM_IRQ = 6,
    localparam int TOP    = NUM_IRQ - 1
) (
    input  logic [NUM_IRQ-1:0] pin_sync_n,
    input  logic [NUM_IRQ-1:0] soft_bits,
    input  logic               timer_req,
    input  logic               timer_off_sync,
    output logic [NUM_IRQ-1:0] pending
);

    genvar k;
    generate
        for (k = 0; k < NUM_IRQ; k++) begin : g_line
            if (k == TOP) begin : g_top
                // Top line: the strap picks the timer or the pin.
                always_comb begin
                    pending[k] = soft_bits[k] |
                                 (timer_off_sync ? !pin_sync_n[k] : timer_req);
                end
            end else begin : g_plain
                // Ordinary line: pin OR register bit.
                always_comb begin
                    pending[k] = soft_bits[k] | !pin_sync_n[k];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_combiner.sv
// Module: interrupt synchronizer and combiner (top).
// What it does: synchronizes the interrupt pins, the non-maskable pin and the
// timer strap, merges them with a software register and drives the pending field,
// a status word holding that field, and a one-cycle non-maskable pulse.
// Assumes: timer_req is already in the clk domain; the strap is quasi-static.
module irq_combiner #(
    parameter int NUM_IRQ     = irq_combiner_pkg::DEF_NUM_IRQ,
    parameter int SYNC_STAGES = irq_combiner_pkg::DEF_SYNC_STAGES,
    parameter int FIELD_LSB   = irq_combiner_pkg::DEF_FIELD_LSB,
    parameter int WORD_W      = irq_combiner_pkg::DEF_WORD_W,
    localparam int REG_W      = NUM_IRQ + 1,
    localparam int SYNC_W     = NUM_IRQ + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_pin_n,
    input  logic               nmi_pin_n,
    input  logic               timer_req,
    input  logic               timer_off,
    input  logic               sw_wr,
    input  logic [REG_W-1:0]   sw_wdata,
    output logic [REG_W-1:0]   sw_rdata,
    output logic [NUM_IRQ-1:0] pend_field,
    output logic [WORD_W-1:0]  cause_word,
    output logic               nmi_req
);

    logic [SYNC_W-1:0]  sync_in;
    logic [SYNC_W-1:0]  sync_out;
    logic [NUM_IRQ-1:0] irq_sync_n;
    logic               nmi_sync;
    logic               strap_sync;
    logic [REG_W-1:0]   soft_val;
    logic               soft_top_rise;

    // Pack every pin and the strap into one synchronizer bus.
    assign sync_in    = {timer_off, nmi_pin_n, irq_pin_n};
    assign irq_sync_n = sync_out[NUM_IRQ-1:0];
    assign nmi_sync   = sync_out[NUM_IRQ];
    assign strap_sync = sync_out[NUM_IRQ+1];

    irq_sync_chain #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({SYNC_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sync_in),
        .q_sync  (sync_out)
    );

    irq_soft_reg #(
        .NUM_IRQ (NUM_IRQ)
    ) u_soft (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (sw_wr),
        .wdata    (sw_wdata),
        .value    (soft_val),
        .top_rise (soft_top_rise)
    );

    irq_merge #(
        .NUM_IRQ (NUM_IRQ)
    ) u_merge (
        .pin_sync_n     (irq_sync_n),
        .soft_bits      (soft_val[NUM_IRQ-1:0]),
        .timer_req      (timer_req),
        .timer_off_sync (strap_sync),
        .pending        (pend_field)
    );

    irq_nmi_pulse u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_sync_n (nmi_sync),
        .sw_rise    (soft_top_rise),
        .nmi_req    (nmi_req)
    );

    // Place the pending field into the status word; other bits stay zero.
    always_comb begin
        cause_word = '0;
        cause_word[FIELD_LSB +: NUM_IRQ] = pend_field;
    end

    assign sw_rdata = soft_val;

endmodule

// File: rtl/irq_combiner_chk.sv
// Module: assertion checker for irq_combiner, attached by bind.
// Assumes: it sees the synchronized strap and non-maskable pin of the top.
module irq_combiner_chk #(
    parameter int NUM_IRQ   = 6,
    parameter int FIELD_LSB = 10,
    parameter int WORD_W    = 16,
    localparam int REG_W    = NUM_IRQ + 1,
    localparam int TOP      = NUM_IRQ - 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sw_wr,
    input logic [REG_W-1:0]   sw_wdata,
    input logic [REG_W-1:0]   sw_rdata,
    input logic [NUM_IRQ-1:0] pend_field,
    input logic [WORD_W-1:0]  cause_word,
    input logic               nmi_req,
    input logic               timer_req,
    input logic               strap_sync,
    input logic               nmi_sync
);

    // R1: reset clears the register and the pulse.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (sw_rdata == '0 && !nmi_req));

    // R3: every set register bit shows in the pending field.
    a_r3_soft_reaches_field: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rdata[NUM_IRQ-1:0] & ~pend_field) == '0);

    // R4: field placement and zero low bits in the status word.
    a_r4_word_layout: assert property (@(posedge clk) disable iff (!rst_n)
        cause_word[FIELD_LSB-1:0] == '0 && cause_word[FIELD_LSB +: NUM_IRQ] == pend_field);

    // R5: with the strap low the timer owns the top line.
    a_r5_timer_owns_top: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_sync |-> pend_field[TOP] == (timer_req | sw_rdata[TOP]));

    // R7: a falling synchronized pin is followed by a pulse.
    a_r7_fall_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_sync) |=> nmi_req);

    // R8: a 0-to-1 write of the top register bit is followed by a pulse.
    a_r8_write_rise_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_wdata[NUM_IRQ] && !sw_rdata[NUM_IRQ]) |=> nmi_req);

    // R9: the read port returns the written value.
    a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> sw_rdata == $past(sw_wdata));

endmodule

bind irq_combiner irq_combiner_chk #(
    .NUM_IRQ   (NUM_IRQ),
    .FIELD_LSB (FIELD_LSB),
    .WORD_W    (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr      (sw_wr),
    .sw_wdata   (sw_wdata),
    .sw_rdata   (sw_rdata),
    .pend_field (pend_field),
    .cause_word (cause_word),
    .nmi_req    (nmi_req),
    .timer_req  (timer_req),
    .strap_sync (strap_sync),
    .nmi_sync   (nmi_sync)
);

// File: tb/tb_irq_combiner.sv
// Bench: scoreboard for irq_combiner. Driver tasks push expected outputs for a
// given cycle; a monitor at the falling edge pops and compares them.
module tb_irq_combiner;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] irq_pin_n;
    logic       nmi_pin_n;
    logic       timer_req;
    logic       timer_off;
    logic       sw_wr;
    logic [6:0] sw_wdata;
    logic [6:0] sw_rdata;
    logic [5:0] pend_field;
    logic [15:0] cause_word;
    logic       nmi_req;

    typedef struct {
        int         cyc;
        logic [5:0] pend;
        logic       nmi;
        logic [6:0] rd;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    irq_combiner dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pin_n  (irq_pin_n),
        .nmi_pin_n  (nmi_pin_n),
        .timer_req  (timer_req),
        .timer_off  (timer_off),
        .sw_wr      (sw_wr),
        .sw_wdata   (sw_wdata),
        .sw_rdata   (sw_rdata),
        .pend_field (pend_field),
        .cause_word (cause_word),
        .nmi_req    (nmi_req)
    );

    // Edge counter used to time expectations.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expectation due in this cycle.
    always @(negedge clk) begin
        int i;
        i = 0;
        while (i < q.size()) begin
            if (q[i].cyc == cyc) begin
                checks++;
                if (pend_field !== q[i].pend || nmi_req !== q[i].nmi ||
                    sw_rdata !== q[i].rd || cause_word !== {q[i].pend, 10'b0}) begin
                    errors++;
                    $display("FAIL %s cyc=%0d: pend=%b nmi=%b rd=%b word=%h, expected pend=%b nmi=%b rd=%b word=%h (R4 layout)",
                             q[i].tag, cyc, pend_field, nmi_req, sw_rdata, cause_word,
                             q[i].pend, q[i].nmi, q[i].rd, {q[i].pend, 10'b0});
                end
                q.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_at(input int d, input logic [5:0] p, input logic n,
                             input logic [6:0] r, input string tag);
        exp_t e;
        e.cyc = cyc + d; e.pend = p; e.nmi = n; e.rd = r; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_pin_n = '1; nmi_pin_n = 1'b1; timer_req = 1'b0;
        timer_off = 1'b1; sw_wr = 1'b0; sw_wdata = '0;
        tick(4);
        rst_n = 1'b1;
        expect_at(0, 6'b0, 1'b0, 7'b0, "R1 reset state");
        expect_at(3, 6'b0, 1'b0, 7'b0, "R1 idle after reset");
        tick(4);

        // R10 latency and R2 single pin.
        irq_pin_n = 6'b111110;
        expect_at(1, 6'b000000, 1'b0, 7'b0, "R10 not yet visible");
        expect_at(2, 6'b000001, 1'b0, 7'b0, "R2 pin0");
        tick(3);
        // R2 pattern with pin5 under strap=1 (R6).
        irq_pin_n = 6'b010101;
        expect_at(2, 6'b101010, 1'b0, 7'b0, "R2 R6 pattern");
        tick(3);
        irq_pin_n = '1;
        expect_at(2, 6'b0, 1'b0, 7'b0, "R2 release");
        tick(3);

        // R6: timer ignored while strap=1.
        timer_req = 1'b1;
        expect_at(0, 6'b0, 1'b0, 7'b0, "R6 timer ignored");
        expect_at(1, 6'b0, 1'b0, 7'b0, "R6 timer ignored");
        tick(2);
        timer_req = 1'b0;
        tick(1);

        // R5: strap=0 gives line 5 to the timer.
        timer_off = 1'b0;
        tick(3);
        timer_req = 1'b1;
        expect_at(0, 6'b100000, 1'b0, 7'b0, "R5 timer drives line5");
        tick(1);
        timer_req = 1'b0;
        irq_pin_n = 6'b011111;
        expect_at(0, 6'b0, 1'b0, 7'b0, "R5 timer drop");
        expect_at(2, 6'b0, 1'b0, 7'b0, "R5 pin5 ignored");
        expect_at(3, 6'b0, 1'b0, 7'b0, "R5 pin5 ignored");
        tick(4);
        irq_pin_n = '1;
        timer_off = 1'b1;
        tick(3);

        // R3 / R9: register ORed with pins.
        sw_wr = 1'b1; sw_wdata = 7'b0010100;
        expect_at(1, 6'b010100, 1'b0, 7'b0010100, "R3 R9 write");
        tick(1);
        sw_wr = 1'b0;
        irq_pin_n = 6'b111011;
        expect_at(2, 6'b010100, 1'b0, 7'b0010100, "R3 overlap with pin2");
        tick(3);
        sw_wr = 1'b1; sw_wdata = 7'b0;
        expect_at(1, 6'b000100, 1'b0, 7'b0, "R3 pin2 remains after clear");
        tick(1);
        sw_wr = 1'b0;
        irq_pin_n = '1;
        expect_at(2, 6'b0, 1'b0, 7'b0, "R3 all clear");
        tick(3);

        // R8: software rise of bit 6.
        sw_wr = 1'b1; sw_wdata = 7'b1000000;
        expect_at(1, 6'b0, 1'b1, 7'b1000000, "R8 pulse");
        expect_at(2, 6'b0, 1'b0, 7'b1000000, "R8 pulse ends");
        tick(1);
        sw_wr = 1'b0;
        tick(2);
        sw_wr = 1'b1; sw_wdata = 7'b1000001;
        expect_at(1, 6'b000001, 1'b0, 7'b1000001, "R8 no pulse when already set");
        tick(1);
        sw_wr = 1'b0;
        tick(1);
        sw_wr = 1'b1; sw_wdata = 7'b0;
        expect_at(1, 6'b0, 1'b0, 7'b0, "R9 cleared");
        tick(1);
        sw_wr = 1'b0;
        tick(2);

        // R7: pin falling edge.
        nmi_pin_n = 1'b0;
        expect_at(2, 6'b0, 1'b0, 7'b0, "R7 not early");
        expect_at(3, 6'b0, 1'b1, 7'b0, "R7 pulse");
        expect_at(4, 6'b0, 1'b0, 7'b0, "R7 single cycle");
        expect_at(8, 6'b0, 1'b0, 7'b0, "R7 held low");
        tick(9);
        nmi_pin_n = 1'b1;
        expect_at(3, 6'b0, 1'b0, 7'b0, "R7 release no pulse");
        expect_at(4, 6'b0, 1'b0, 7'b0, "R7 release no pulse");
        tick(6);

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard drain: actual=%0d pending expected=0", q.size());
        end
        done = 1;
        report();
        $finish;
    end

endmodule